// File: doc/BRIEF.md
# Four-Channel Compare/Capture Timer

This block is a 16-bit free-running counter with four timing channels. The counter advances by one on each cycle where the count-enable input is high. Channels 1 to 3 always work as output compares. Channel 4 works as a fourth output compare or, when a mode bit is set, as an input capture. An output-compare channel fires when the counter reaches its compare value. When it fires, it sets its status flag and applies a programmed action to its output pin.

Software can also force a channel. A forced channel applies the same pin action at the next count step, but it leaves the flag untouched. The three dedicated compare channels share one interrupt line, so software must poll the flags to find the source. Channel 4 has its own interrupt line.

All registers sit on a plain register bus with single-cycle writes and a combinational read path. There is no back-pressure on this bus: every write is taken in the cycle it is presented. The pins, the count enable and the capture input are plain level signals.

Top module: `cmpcap_timer`

Register addresses (4-bit `bus_addr_i`):

| Address | Register |
|---|---|
| 0 to 3 | Channel value registers for channels 1 to 4 |
| 4 | Control register |
| 5 | Force register |
| 6 | Flags register |
| 7 | Mask register |
| 8 | Counter (read only) |

## Requirements
- R1: After reset, the following all read zero: the counter, all value registers, the control, flags and mask registers, and all pins. Both interrupt outputs are low.
- R2: On every clock where `tick_i` is high, the counter (read at address 8) increments by one, wrapping from 0xFFFF to 0. With `tick_i` low it holds.
- R3: A compare channel matches when `tick_i` is high and the counter's new value equals that channel's value register. Value registers for channels 1 to 4 are at addresses 0 to 3. On that same edge, flag bit i-1 (flags register at address 6) is set for channel i.
- R4: Control register bits [2i-1:2i-2] select the action for channel i's pin (`pin_o[i-1]`). The codes are: 00 no effect, 01 toggle, 10 drive low, 11 drive high. The action is applied on the edge of the match.
- R5: Writing the force register (address 5) with bit i-1 set arms channel i. The armed channel's action is applied at the next tick after the write, and its flag is not set. Bits above 3 are ignored, and the register always reads 0.
- R6: If a real match and an armed force land on the same tick, the action is applied once, so toggle mode toggles only once.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins.
- R8: `irq_cmp_o` is high when any of flag bits 0 to 2 is set together with the same bit of the mask register (address 7). `irq_ch4_o` is high when flag bit 3 and mask bit 3 are both set.
- R9: Control bit 8 set puts channel 4 in capture mode. In this mode, channel 4 never matches and its pin is not changed.
- R10: In capture mode, `cap_pin_i` passes through two synchronizing flops before edge detection. On the selected edge, value register 4 loads the counter and flag bit 3 is set. Control bits [10:9] select the edge: 00 none, 01 rising, 10 falling, 11 either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable; the counter steps on cycles where it is high |
| bus_sel_i | input | 1 | Bus select |
| bus_we_i | input | 1 | Write strobe, used together with select |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| cap_pin_i | input | 1 | Asynchronous capture input for channel 4 |
| pin_o | output | 4 | Channel output pins, channel 1 on bit 0 |
| irq_cmp_o | output | 1 | Shared interrupt for channels 1 to 3 |
| irq_ch4_o | output | 1 | Interrupt for channel 4 |

## Verification
The assertions assume that reset is held for at least one clock with `tick_i` low. They also assume that `tick_i` and the bus signals change only away from the rising edge.

The capture checks assume that `cap_pin_i` holds each level for at least three clocks, so the synchronizer sees every edge. The stimulus meets this by waiting four clocks after every pin change.

The stimulus also writes only the defined register addresses. It applies a flag clear in the same cycle as a match only in the one test aimed at that collision.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int NCH    = 4;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd4;
  localparam logic [ADDR_W-1:0] A_FORCE = 4'd5;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_o == W'($past(cnt_o) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] edge_sel_i,
  input  logic       pin_i,
  output logic       evt_o
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise  = s2_q & ~s3_q;
  assign fall  = ~s2_q & s3_q;
  assign evt_o = en_i & ((edge_sel_i[0] & rise) | (edge_sel_i[1] & fall));
endmodule

// File: rtl/tmr_oc_chan.sv
`timescale 1ns/1ps
module tmr_oc_chan import tmr_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  act_e         act_i,
  input  logic         force_i,
  output logic         match_o,
  output logic         pin_o
);
  logic pend_q;
  logic fire;

  assign match_o = tick_i & en_i & (cnt_nxt_i == cmp_i);
  assign fire    = tick_i & en_i & (match_o | pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (force_i && en_i)  pend_q <= 1'b1;
    else if (tick_i)           pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_o <= 1'b0;
    else if (fire) begin
      case (act_i)
        ACT_TOGGLE: pin_o <= ~pin_o;
        ACT_LOW:    pin_o <= 1'b0;
        ACT_HIGH:   pin_o <= 1'b1;
        default:    pin_o <= pin_o;
      endcase
    end
  end

  AST_PIN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pin_o)); // R4
  AST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en_i && (match_o || pend_q) && act_i == ACT_HIGH) |=> pin_o); // R4
  AST_FORCE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !force_i) |=> !pend_q); // R5
endmodule

// File: rtl/cmpcap_timer.sv
`timescale 1ns/1ps
module cmpcap_timer import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              cap_pin_i,
  output logic [NCH-1:0]    pin_o,
  output logic              irq_cmp_o,
  output logic              irq_ch4_o
);
  localparam int CTRL_W   = 2*NCH + 3;
  localparam int MODE_BIT = 2*NCH;
  localparam int EDGE_LSB = 2*NCH + 1;
  localparam int DUAL     = NCH - 1;

  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [CNT_W-1:0]  val_q [NCH];
  logic [CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0]    flag_q, mask_q, match, force_set, set_vec, chan_en;
  logic [NCH-1:0]    clr_vec;
  logic              wr, flag_wr, cap_mode, cap_evt;

  assign wr       = bus_sel_i & bus_we_i;
  assign flag_wr  = wr && (bus_addr_i == A_FLAG);
  assign cap_mode = ctrl_q[MODE_BIT];
  assign cnt_nxt  = cnt + 1'b1;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_o(cnt)
  );

  tmr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .en_i(cap_mode),
    .edge_sel_i(ctrl_q[EDGE_LSB +: 2]), .pin_i(cap_pin_i), .evt_o(cap_evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign chan_en[g]   = (g == DUAL) ? ~cap_mode : 1'b1;
    assign force_set[g] = wr && (bus_addr_i == A_FORCE) && bus_wdata_i[g];
    assign set_vec[g]   = match[g] | ((g == DUAL) ? cap_evt : 1'b0);

    tmr_oc_chan #(.W(CNT_W)) u_oc (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(chan_en[g]),
      .cmp_i(val_q[g]), .cnt_nxt_i(cnt_nxt),
      .act_i(act_e'(ctrl_q[2*g +: 2])), .force_i(force_set[g]),
      .match_o(match[g]), .pin_o(pin_o[g])
    );

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !(flag_wr && bus_wdata_i[g])) |=> flag_q[g]); // R7
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      match[g] |=> flag_q[g]); // R3
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) val_q[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (i == DUAL && cap_evt)
          val_q[i] <= cnt;
        else if (wr && bus_addr_i == ADDR_W'(i))
          val_q[i] <= bus_wdata_i;
      end
    end
  end

  assign clr_vec = flag_wr ? bus_wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr && bus_addr_i == A_CTRL) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
      if (wr && bus_addr_i == A_MASK) mask_q <= bus_wdata_i[NCH-1:0];
      flag_q <= (flag_q & ~clr_vec) | set_vec;
    end
  end

  assign irq_cmp_o = |(flag_q[DUAL-1:0] & mask_q[DUAL-1:0]);
  assign irq_ch4_o = flag_q[DUAL] & mask_q[DUAL];

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (bus_addr_i == ADDR_W'(i)) bus_rdata_o = val_q[i];
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o[CTRL_W-1:0] = ctrl_q;
      A_FLAG:  bus_rdata_o[NCH-1:0]    = flag_q;
      A_MASK:  bus_rdata_o[NCH-1:0]    = mask_q;
      A_CNT:   bus_rdata_o             = cnt;
      default: ;
    endcase
  end

  AST_CAP_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode |-> !match[DUAL]); // R9
  AST_CAP_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && $past(cap_mode)) |-> $stable(pin_o[DUAL])); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp_o |-> (flag_q[DUAL-1:0] != '0)); // R8
endmodule

// File: tb/test_cmpcap_timer.sv
`timescale 1ns/1ps
module test_cmpcap_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cap_pin = 1'b0;
  logic [3:0]  pins;
  logic        irq_cmp, irq_ch4;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  cmpcap_timer i_cmpcap_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cap_pin_i(cap_pin), .pin_o(pins), .irq_cmp_o(irq_cmp), .irq_ch4_o(irq_ch4)
  );

  // {waddr, wdata, ticks, raddr, expected read, expected pins}
  localparam logic [51:0] VEC [12] = '{
    {4'd7, 16'h000F, 8'd0, 4'd7, 16'h000F, 4'b0000},  // R8 mask
    {4'd0, 16'h0003, 8'd0, 4'd0, 16'h0003, 4'b0000},  // R3 value 1
    {4'd4, 16'h00ED, 8'd0, 4'd4, 16'h00ED, 4'b0000},  // R4 actions
    {4'd1, 16'h0005, 8'd0, 4'd8, 16'h0000, 4'b0000},  // R2 no tick yet
    {4'd3, 16'h0004, 8'd0, 4'd3, 16'h0004, 4'b0000},  // R3 value 4
    {4'd2, 16'h0006, 8'd3, 4'd6, 16'h0001, 4'b0001},  // R3 R4 toggle
    {4'd6, 16'h0001, 8'd1, 4'd6, 16'h0008, 4'b1001},  // R4 high ch4, R7
    {4'd6, 16'h0008, 8'd1, 4'd6, 16'h0002, 4'b1011},  // R4 high ch2
    {4'd6, 16'h0002, 8'd1, 4'd6, 16'h0004, 4'b1011},  // R4 low ch3
    {4'd5, 16'h00F1, 8'd0, 4'd5, 16'h0000, 4'b1011},  // R5 armed, not yet
    {4'd6, 16'h0004, 8'd1, 4'd6, 16'h0000, 4'b1010},  // R5 fired, no flag
    {4'd0, 16'h0009, 8'd2, 4'd8, 16'h0009, 4'b1011}   // R2 R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    wait_clk(200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    wait_clk(3);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(4'd8, d); check("R1 count", d, 0);
    rd(4'd6, d); check("R1 flags", d, 0);
    rd(4'd4, d); check("R1 ctrl", d, 0);
    check("R1 pins", pins, 0);
    check("R1 irq", {irq_cmp, irq_ch4}, 0);

    for (int k = 0; k < 12; k++) begin
      bus_wr(VEC[k][51:48], VEC[k][47:32]);
      ticks(int'(VEC[k][31:24]));
      rd(VEC[k][23:20], d);
      check($sformatf("R3/R4/R5 vector %0d read", k), d, VEC[k][19:4]);
      check($sformatf("R4 vector %0d pins", k), pins, VEC[k][3:0]);
    end

    // R8 shared interrupt
    check("R8 irq_cmp set", irq_cmp, 1);
    check("R8 irq_ch4 clear", irq_ch4, 0);
    bus_wr(4'd7, 16'h0008);
    #1 check("R8 irq_cmp masked", irq_cmp, 0);
    bus_wr(4'd6, 16'h0001);
    bus_wr(4'd7, 16'h000F);

    // R6 force and match on the same tick
    bus_wr(4'd0, 16'd11);
    ticks(1);
    bus_wr(4'd5, 16'h0001);
    ticks(1);
    check("R6 single toggle", pins[0], 0);
    rd(4'd6, d); check("R6 flag from match", d, 16'h0001);

    // R7 set wins over clear
    bus_wr(4'd0, 16'd13);
    ticks(1);
    @(negedge clk);
    tick = 1'b1; sel = 1'b1; we = 1'b1; addr = 4'd6; wdata = 16'h0001;
    @(negedge clk);
    tick = 1'b0; sel = 1'b0; we = 1'b0;
    rd(4'd6, d); check("R7 set wins", d, 16'h0001);
    bus_wr(4'd6, 16'h0001);
    rd(4'd6, d); check("R7 clear", d, 16'h0000);

    // R10 capture, rising edge
    bus_wr(4'd4, 16'h03ED);
    @(negedge clk) cap_pin = 1'b1;
    wait_clk(4);
    rd(4'd3, d); check("R10 rising capture", d, 16'd13);
    rd(4'd6, d); check("R10 capture flag", d, 16'h0008);
    bus_wr(4'd6, 16'h0008);
    ticks(2);
    @(negedge clk) cap_pin = 1'b0;
    wait_clk(4);
    rd(4'd6, d); check("R10 falling ignored", d, 16'h0000);
    rd(4'd3, d); check("R10 value kept", d, 16'd13);

    // R10 falling edge select, R9 compare off
    bus_wr(4'd4, 16'h05AD);
    @(negedge clk) cap_pin = 1'b1;
    wait_clk(4);
    rd(4'd6, d); check("R10 rising ignored", d, 16'h0000);
    ticks(1);
    @(negedge clk) cap_pin = 1'b0;
    wait_clk(4);
    rd(4'd3, d); check("R10 falling capture", d, 16'd16);
    bus_wr(4'd6, 16'h0008);
    bus_wr(4'd3, 16'd17);
    ticks(1);
    check("R9 pin untouched", pins[3], 1);
    rd(4'd6, d); check("R9 no flag", d, 16'h0000);

    // R2 hold and wrap
    wait_clk(3);
    rd(4'd8, d); check("R2 hold", d, 16'd17);
    ticks(65518);
    rd(4'd8, d); check("R2 top", d, 16'hFFFF);
    ticks(1);
    rd(4'd8, d); check("R2 wrap", d, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule